// File: doc/BRIEF.md
# Cascaded Dual Interrupt Controller

This block joins two eight-line interrupt controllers into one unit that drives a single interrupt request toward a processor. The primary bank takes device lines 0 to 7 and the secondary bank takes lines 8 to 15. The secondary bank's request output is wired into primary line 2, so that input is not available to devices and fifteen device lines remain usable. Only the primary bank drives the processor request pin.

A rising edge on an unmasked device line is latched as pending. Within each bank the lowest-numbered line wins. Every secondary line ranks at the position of primary line 2, so the full order is 0, 1, 8 to 15, then 3 to 7. A request reaches the processor only if it outranks every line already in service. The processor pulses an acknowledge. One cycle later the unit returns an 8-bit vector with a valid strobe and marks the source in service. A secondary source is marked in service in both banks.

Software reaches the unit through a small byte-wide register port. Each bank has a command address and a data address. The data address holds the line mask. The command address accepts end-of-interrupt and vector-base commands and reads back the in-service bits.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, cpuIrq and vecValid are low, both masks are 0x00 and both in-service registers are 0x00. The vector bases reset to 0x08 for the primary bank and 0x70 for the secondary bank.
- R2: A rising edge on an unmasked primary line n (n other than 2) raises cpuIrq at the next clock edge. An acknowledge then returns vector primaryBase + n and sets in-service bit n of the primary bank.
- R3: A rising edge on an unmasked secondary line 8+j raises cpuIrq. An acknowledge returns secondaryBase + j, sets in-service bit j of the secondary bank, and sets in-service bit 2 of the primary bank.
- R4: When several lines are pending, the acknowledge picks the line first in the order 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7.
- R5: Writing the data address of a bank (primary 0x21, secondary 0xA1) sets its mask, where bit n masks line n. A rising edge on a masked line is not latched. A line that is already pending but masked does not drive cpuIrq until it is unmasked. Masking primary bit 2 hides every secondary request.
- R6: A pending line does not raise cpuIrq while a line of equal or higher rank is in service. A higher-ranked line still interrupts over a lower-ranked line in service. A secondary line is blocked while primary in-service bit 2 is set.
- R7: A write to a command address (primary 0x20, secondary 0xA0) with bit 7 clear and bit 5 set clears the lowest-numbered set in-service bit of that bank. Clearing a secondary source takes this command at both banks. Command values with bit 7 and bit 5 both clear change nothing.
- R8: A command write with bit 7 set loads that bank's vector base as {data[4:0], 3'b000}. The mask is unchanged.
- R9: An acknowledge while cpuIrq is low returns primaryBase + 7 and changes no in-service bit.
- R10: Device input bit 2 has no effect.
- R11: A read at a data address returns that bank's mask. A read at a command address returns that bank's in-service bits. Any other address reads 0x00. The read path is combinational.
- R12: vecValid is high for exactly the one cycle after each cycle in which ackReq is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devIrq | input | 16 | Device request lines; bit 2 unused |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register port address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| cpuIrq | output | 1 | Interrupt request to the processor |
| ackReq | input | 1 | Processor acknowledge pulse |
| vecValid | output | 1 | Vector valid, one cycle after ackReq |
| vecOut | output | 8 | Returned vector |

## Verification
The assertions check on every cycle that the vector strobe follows the acknowledge by exactly one cycle, and that an acknowledge marks the winning line in service. For a cascaded source they check that both banks are marked. They also check the spurious vector and the unchanged in-service bits when no request is raised, that an end-of-interrupt clears exactly one in-service bit, and that a full mask or line 0 in service keeps cpuIrq low. The bench's scenarios cover behaviour that needs a history of stimulus. This includes the ranking of every pair of lines against the cascade, and the drop of a masked edge that stays lost after unmasking. It also covers the requirement for end-of-interrupt at both banks before a further secondary request can reach the processor, and the effect of reprogrammed bases.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_LINES = 8;
  localparam int IDX_W     = $clog2(IRQ_LINES);
  localparam int DATA_W    = 8;

  // Per-bank strobes from the sequencer to the bank datapath.
  typedef struct packed {
    logic              wrMask;
    logic              wrBase;
    logic              eoi;
    logic              ack;
    logic [IDX_W-1:0]  ackIdx;
    logic [DATA_W-1:0] wrData;
  } bank_strobe_t;
endpackage

// File: rtl/irq_bank.sv
module irq_bank
  import irq_pkg::*;
#(
  parameter logic [DATA_W-1:0]    RESET_BASE  = 8'h08,
  parameter logic [IRQ_LINES-1:0] LEVEL_LINES = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IRQ_LINES-1:0] reqIn,
  input  bank_strobe_t         stb,
  output logic                 intOut,
  output logic [IDX_W-1:0]     winIdx,
  output logic [IRQ_LINES-1:0] isrOut,
  output logic [IRQ_LINES-1:0] maskOut,
  output logic [DATA_W-1:0]    baseOut
);
  localparam int BASE_HI_W = DATA_W - IDX_W;

  logic [IRQ_LINES-1:0] prevIn, irrQ, isrQ, maskQ;
  logic [DATA_W-1:0]    baseQ;
  logic [IRQ_LINES-1:0] edgeHit, liveReq, pendVec, ackBit, eoiBit;
  logic                 hasWin, isrAny;
  logic [IDX_W-1:0]     isrTop;

  // Edge lines latch only when unmasked; level lines follow their input.
  assign edgeHit = reqIn & ~prevIn & ~maskQ & ~LEVEL_LINES;
  assign liveReq = (irrQ & ~LEVEL_LINES) | (reqIn & LEVEL_LINES);
  assign pendVec = liveReq & ~maskQ;

  // Lowest-numbered pending line wins.
  always_comb begin
    hasWin = 1'b0;
    winIdx = '0;
    for (int i = IRQ_LINES - 1; i >= 0; i--) begin
      if (pendVec[i]) begin
        hasWin = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
  end

  // Highest-ranked line currently in service.
  always_comb begin
    isrAny = 1'b0;
    isrTop = '0;
    for (int i = IRQ_LINES - 1; i >= 0; i--) begin
      if (isrQ[i]) begin
        isrAny = 1'b1;
        isrTop = IDX_W'(i);
      end
    end
  end

  assign intOut = hasWin && (!isrAny || (winIdx < isrTop));
  assign ackBit = stb.ack ? (IRQ_LINES'(1) << stb.ackIdx) : '0;
  assign eoiBit = (stb.eoi && isrAny) ? (IRQ_LINES'(1) << isrTop) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIn <= '0;
      irrQ   <= '0;
      isrQ   <= '0;
      maskQ  <= '0;
      baseQ  <= RESET_BASE;
    end else begin
      prevIn <= reqIn;
      irrQ   <= (irrQ & ~ackBit) | edgeHit;
      isrQ   <= (isrQ & ~eoiBit) | ackBit;
      if (stb.wrMask) maskQ <= stb.wrData[IRQ_LINES-1:0];
      if (stb.wrBase) baseQ <= {stb.wrData[BASE_HI_W-1:0], {IDX_W{1'b0}}};
    end
  end

  assign isrOut  = isrQ;
  assign maskOut = maskQ;
  assign baseOut = baseQ;
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_pkg::*;
#(
  parameter int                ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] M_CMD        = 8'h20,
  parameter logic [ADDR_W-1:0] M_DATA       = 8'h21,
  parameter logic [ADDR_W-1:0] S_CMD        = 8'hA0,
  parameter logic [ADDR_W-1:0] S_DATA       = 8'hA1,
  parameter int                CASCADE_LINE = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic                 ackReq,
  input  logic                 mInt,
  input  logic [IDX_W-1:0]     mWin,
  input  logic [IDX_W-1:0]     sWin,
  input  logic [DATA_W-1:0]    mBase,
  input  logic [DATA_W-1:0]    sBase,
  input  logic [IRQ_LINES-1:0] mIsr,
  input  logic [IRQ_LINES-1:0] sIsr,
  input  logic [IRQ_LINES-1:0] mMask,
  input  logic [IRQ_LINES-1:0] sMask,
  output bank_strobe_t         mStb,
  output bank_strobe_t         sStb,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 vecValid,
  output logic [DATA_W-1:0]    vecOut
);
  localparam logic [IDX_W-1:0]  CASC_IDX  = IDX_W'(CASCADE_LINE);
  localparam logic [DATA_W-1:0] SPUR_OFFS = DATA_W'(IRQ_LINES - 1);

  logic [DATA_W-1:0] vecNext;

  function automatic bank_strobe_t decodeWrite(logic hitCmd, logic hitData,
                                               logic [DATA_W-1:0] d);
    bank_strobe_t s;
    s        = '0;
    s.wrData = d;
    s.wrMask = hitData;
    s.wrBase = hitCmd && d[7];
    s.eoi    = hitCmd && !d[7] && d[5];
    return s;
  endfunction

  always_comb begin
    mStb    = decodeWrite(regWrEn && (regAddr == M_CMD),
                          regWrEn && (regAddr == M_DATA), regWrData);
    sStb    = decodeWrite(regWrEn && (regAddr == S_CMD),
                          regWrEn && (regAddr == S_DATA), regWrData);
    vecNext = mBase + SPUR_OFFS;
    if (ackReq && mInt) begin
      mStb.ack    = 1'b1;
      mStb.ackIdx = mWin;
      if (mWin == CASC_IDX) begin
        sStb.ack    = 1'b1;
        sStb.ackIdx = sWin;
        vecNext     = sBase + DATA_W'(sWin);
      end else begin
        vecNext = mBase + DATA_W'(mWin);
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      M_CMD:   regRdData = DATA_W'(mIsr);
      M_DATA:  regRdData = DATA_W'(mMask);
      S_CMD:   regRdData = DATA_W'(sIsr);
      S_DATA:  regRdData = DATA_W'(sMask);
      default: regRdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecValid <= 1'b0;
      vecOut   <= '0;
    end else begin
      vecValid <= ackReq;
      if (ackReq) vecOut <= vecNext;
    end
  end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import irq_pkg::*;
#(
  parameter int                ADDR_W           = 8,
  parameter logic [ADDR_W-1:0] MASTER_CMD_ADDR  = 8'h20,
  parameter logic [ADDR_W-1:0] MASTER_DATA_ADDR = 8'h21,
  parameter logic [ADDR_W-1:0] SLAVE_CMD_ADDR   = 8'hA0,
  parameter logic [ADDR_W-1:0] SLAVE_DATA_ADDR  = 8'hA1,
  parameter logic [DATA_W-1:0] MASTER_BASE_RST  = 8'h08,
  parameter logic [DATA_W-1:0] SLAVE_BASE_RST   = 8'h70,
  parameter int                CASCADE_LINE     = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [2*IRQ_LINES-1:0] devIrq,
  input  logic                   regWrEn,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [DATA_W-1:0]      regWrData,
  output logic [DATA_W-1:0]      regRdData,
  output logic                   cpuIrq,
  input  logic                   ackReq,
  output logic                   vecValid,
  output logic [DATA_W-1:0]      vecOut
);
  localparam logic [IRQ_LINES-1:0] CASC_MASK = IRQ_LINES'(1) << CASCADE_LINE;

  bank_strobe_t         mStb, sStb;
  logic                 sInt;
  logic [IDX_W-1:0]     mWin, sWin;
  logic [IRQ_LINES-1:0] mReq, mIsr, sIsr, mMask, sMask;
  logic [DATA_W-1:0]    mBase, sBase;

  // The secondary request replaces device bit on the cascade input.
  always_comb begin
    mReq               = devIrq[IRQ_LINES-1:0];
    mReq[CASCADE_LINE] = sInt;
  end

  irq_bank #(.RESET_BASE(MASTER_BASE_RST), .LEVEL_LINES(CASC_MASK)) u_master (
    .clk(clk), .rstN(rstN), .reqIn(mReq), .stb(mStb), .intOut(cpuIrq),
    .winIdx(mWin), .isrOut(mIsr), .maskOut(mMask), .baseOut(mBase)
  );

  irq_bank #(.RESET_BASE(SLAVE_BASE_RST), .LEVEL_LINES('0)) u_slave (
    .clk(clk), .rstN(rstN), .reqIn(devIrq[2*IRQ_LINES-1:IRQ_LINES]), .stb(sStb),
    .intOut(sInt), .winIdx(sWin), .isrOut(sIsr), .maskOut(sMask), .baseOut(sBase)
  );

  irq_seq #(
    .ADDR_W(ADDR_W), .M_CMD(MASTER_CMD_ADDR), .M_DATA(MASTER_DATA_ADDR),
    .S_CMD(SLAVE_CMD_ADDR), .S_DATA(SLAVE_DATA_ADDR), .CASCADE_LINE(CASCADE_LINE)
  ) u_seq (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .ackReq(ackReq), .mInt(cpuIrq), .mWin(mWin),
    .sWin(sWin), .mBase(mBase), .sBase(sBase), .mIsr(mIsr), .sIsr(sIsr),
    .mMask(mMask), .sMask(sMask), .mStb(mStb), .sStb(sStb),
    .regRdData(regRdData), .vecValid(vecValid), .vecOut(vecOut)
  );
endmodule

// File: rtl/irq_checker.sv
module irq_checker
  import irq_pkg::*;
#(
  parameter int                ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR     = 8'h20,
  parameter int                CASCADE_LINE = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 ackReq,
  input logic                 cpuIrq,
  input logic                 vecValid,
  input logic [DATA_W-1:0]    vecOut,
  input logic                 regWrEn,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [DATA_W-1:0]    regWrData,
  input logic [IRQ_LINES-1:0] mIsr,
  input logic [IRQ_LINES-1:0] sIsr,
  input logic [IRQ_LINES-1:0] mMask,
  input logic [DATA_W-1:0]    mBase,
  input logic [IDX_W-1:0]     mWin
);
  localparam logic [DATA_W-1:0] SPUR_OFFS = DATA_W'(IRQ_LINES - 1);
  localparam logic [IDX_W-1:0]  CASC_IDX  = IDX_W'(CASCADE_LINE);

  p_vec_after_ack_r12: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |=> vecValid);

  p_vec_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    !ackReq |=> !vecValid);

  p_spurious_vec_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && !cpuIrq && !regWrEn) |=>
      ((vecOut == ($past(mBase) | SPUR_OFFS)) && $stable(mIsr)));

  p_ack_sets_isr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && cpuIrq && !regWrEn) |=> mIsr[$past(mWin)]);

  p_cascade_both_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && cpuIrq && (mWin == CASC_IDX) && !regWrEn) |=>
      (mIsr[CASCADE_LINE] && ($countones(sIsr) == $countones($past(sIsr)) + 1)));

  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mMask == '1) |-> !cpuIrq);

  p_top_blocks_r6: assert property (@(posedge clk) disable iff (!rstN)
    mIsr[0] |-> !cpuIrq);

  p_eoi_one_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr == CMD_ADDR) && !regWrData[7] && regWrData[5] && !ackReq) |=>
      ($countones(mIsr) + (($past(mIsr) != '0) ? 1 : 0) == $countones($past(mIsr))));
endmodule

bind cascade_irq_ctrl irq_checker #(
  .ADDR_W(ADDR_W), .CMD_ADDR(MASTER_CMD_ADDR), .CASCADE_LINE(CASCADE_LINE)
) u_chk (
  .clk(clk), .rstN(rstN), .ackReq(ackReq), .cpuIrq(cpuIrq), .vecValid(vecValid),
  .vecOut(vecOut), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .mIsr(mIsr), .sIsr(sIsr), .mMask(mMask), .mBase(mBase), .mWin(mWin)
);

// File: tb/cascade_irq_ctrl_tb.sv
module cascade_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] devIrq = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        cpuIrq;
  logic        ackReq = 1'b0;
  logic        vecValid;
  logic [7:0]  vecOut;

  int checks = 0;
  int failures = 0;
  int mBase = 8'h08;
  int sBase = 8'h70;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cascade_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .devIrq(devIrq), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cpuIrq(cpuIrq), .ackReq(ackReq),
    .vecValid(vecValid), .vecOut(vecOut)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic writeReg(int a, int d);
    regAddr = 8'(a); regWrData = 8'(d); regWrEn = 1'b1;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic readReg(int a, output int v);
    regAddr = 8'(a);
    #1;
    v = int'(regRdData);
  endtask

  task automatic pulse(int n);
    devIrq[n] = 1'b1;
    step();
    devIrq[n] = 1'b0;
  endtask

  task automatic doAck(output int v, output int valid);
    ackReq = 1'b1;
    step();
    ackReq = 1'b0;
    v = int'(vecOut);
    valid = int'(vecValid);
  endtask

  task automatic eoiLine(int n);
    if (n >= 8) writeReg(8'hA0, 8'h20);
    writeReg(8'h20, 8'h20);
  endtask

  function automatic int expVec(int n);
    return (n < 8) ? mBase + n : sBase + n - 8;
  endfunction

  function automatic int rankOf(int n);
    if (n < 2) return n;
    if (n >= 8) return n - 6;
    return n + 8;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v, valid, rd;
    // R1 reset state
    repeat (3) step();
    check("R1", "cpuIrq in reset", int'(cpuIrq), 0);
    check("R1", "vecValid in reset", int'(vecValid), 0);
    readReg(8'h20, rd); check("R1", "primary isr", rd, 0);
    readReg(8'h21, rd); check("R1", "primary mask", rd, 0);
    readReg(8'hA0, rd); check("R1", "secondary isr", rd, 0);
    readReg(8'hA1, rd); check("R1", "secondary mask", rd, 0);
    rstN = 1'b1;
    step();
    check("R1", "cpuIrq idle", int'(cpuIrq), 0);

    // R2 / R3 / R12 single-line sweep
    for (int n = 0; n < 16; n++) begin
      if (n == 2) continue;
      pulse(n);
      check(n < 8 ? "R2" : "R3", $sformatf("cpuIrq line %0d", n), int'(cpuIrq), 1);
      doAck(v, valid);
      check(n < 8 ? "R2" : "R3", $sformatf("vector line %0d", n), v, expVec(n));
      check("R12", "vecValid after ack", valid, 1);
      step();
      check("R12", "vecValid one cycle", int'(vecValid), 0);
      check("R6", "cpuIrq after ack", int'(cpuIrq), 0);
      readReg(8'h20, rd);
      check(n < 8 ? "R2" : "R3", "primary isr", rd, (n < 8) ? (1 << n) : 4);
      if (n >= 8) begin
        readReg(8'hA0, rd);
        check("R3", "secondary isr", rd, 1 << (n - 8));
      end
      eoiLine(n);
      readReg(8'h20, rd); check("R7", "primary isr cleared", rd, 0);
      readReg(8'hA0, rd); check("R7", "secondary isr cleared", rd, 0);
    end

    // R4 pairwise ranking, with R6 / R7 blocking on the way
    for (int a = 0; a < 16; a++) begin
      for (int b = a + 1; b < 16; b++) begin
        int first, second;
        if (a == 2 || b == 2) continue;
        first  = (rankOf(a) < rankOf(b)) ? a : b;
        second = (first == a) ? b : a;
        devIrq[a] = 1'b1; devIrq[b] = 1'b1;
        step();
        devIrq = '0;
        doAck(v, valid);
        check("R4", $sformatf("winner of %0d,%0d", a, b), v, expVec(first));
        check("R6", "lower rank blocked", int'(cpuIrq), 0);
        if (first >= 8) begin
          writeReg(8'hA0, 8'h20);
          check("R7", "blocked until primary eoi", int'(cpuIrq), 0);
        end
        writeReg(8'h20, 8'h20);
        check("R4", "second raised", int'(cpuIrq), 1);
        doAck(v, valid);
        check("R4", $sformatf("second of %0d,%0d", a, b), v, expVec(second));
        eoiLine(second);
        check("R4", "idle after pair", int'(cpuIrq), 0);
      end
    end

    // R6 nesting on the primary bank
    pulse(5); doAck(v, valid);
    pulse(1);
    check("R6", "higher rank interrupts", int'(cpuIrq), 1);
    doAck(v, valid);
    check("R6", "nested vector", v, 8'h09);
    writeReg(8'h20, 8'h00);
    readReg(8'h20, rd); check("R7", "plain command ignored", rd, 8'h22);
    writeReg(8'h20, 8'h20);
    readReg(8'h20, rd); check("R7", "lowest isr cleared", rd, 8'h20);
    writeReg(8'h20, 8'h20);
    readReg(8'h20, rd); check("R7", "isr empty", rd, 0);
    writeReg(8'h20, 8'h20);
    readReg(8'h20, rd); check("R7", "eoi on empty isr", rd, 0);

    // R6 secondary lines blocked by primary line 2 in service
    pulse(12); doAck(v, valid);
    pulse(9);
    check("R6", "secondary blocked by cascade isr", int'(cpuIrq), 0);
    writeReg(8'hA0, 8'h20);
    check("R7", "still blocked after secondary eoi", int'(cpuIrq), 0);
    writeReg(8'h20, 8'h20);
    check("R7", "raised after both eoi", int'(cpuIrq), 1);
    doAck(v, valid);
    check("R3", "vector line 9", v, 8'h71);
    eoiLine(9);

    // R5 masking
    pulse(4);
    writeReg(8'h21, 8'h10);
    check("R5", "masked pending quiet", int'(cpuIrq), 0);
    readReg(8'h21, rd); check("R11", "mask readback", rd, 8'h10);
    writeReg(8'h21, 8'h00);
    check("R5", "unmasked pending raises", int'(cpuIrq), 1);
    doAck(v, valid); check("R5", "vector line 4", v, 8'h0C);
    eoiLine(4);
    writeReg(8'h21, 8'h08);
    pulse(3);
    check("R5", "masked edge quiet", int'(cpuIrq), 0);
    writeReg(8'h21, 8'h00);
    check("R5", "masked edge not latched", int'(cpuIrq), 0);
    writeReg(8'hA1, 8'h04);
    pulse(10);
    check("R5", "secondary masked edge", int'(cpuIrq), 0);
    readReg(8'hA1, rd); check("R11", "secondary mask readback", rd, 8'h04);
    writeReg(8'hA1, 8'h00);
    check("R5", "secondary edge dropped", int'(cpuIrq), 0);
    writeReg(8'h21, 8'h04);
    pulse(11);
    check("R5", "cascade mask hides secondary", int'(cpuIrq), 0);
    writeReg(8'h21, 8'h00);
    check("R5", "secondary latched behind cascade mask", int'(cpuIrq), 1);
    doAck(v, valid); check("R5", "vector line 11", v, 8'h73);
    eoiLine(11);

    // R9 spurious and R10 ignored bit 2
    doAck(v, valid);
    check("R9", "spurious vector", v, 8'h0F);
    readReg(8'h20, rd); check("R9", "no isr on spurious", rd, 0);
    pulse(2);
    check("R10", "bit 2 ignored", int'(cpuIrq), 0);
    doAck(v, valid);
    check("R10", "bit 2 gives spurious", v, 8'h0F);
    readReg(8'h20, rd); check("R10", "isr untouched", rd, 0);

    // R11 unmapped address
    readReg(8'h55, rd); check("R11", "unmapped read", rd, 0);

    // R8 base programming
    writeReg(8'h20, 8'h85); mBase = 8'h28;
    writeReg(8'hA0, 8'h9F); sBase = 8'hF8;
    readReg(8'h21, rd); check("R8", "mask unchanged by base", rd, 0);
    pulse(6); doAck(v, valid);
    check("R8", "new primary base", v, 8'h2E);
    eoiLine(6);
    pulse(13); doAck(v, valid);
    check("R8", "new secondary base", v, 8'hFD);
    eoiLine(13);
    doAck(v, valid);
    check("R9", "spurious with new base", v, 8'h2F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule